// File: doc/BRIEF.md
# ATA PIO Register Access Controller

This block carries out one programmed-I/O register access at a time to an ATA/IDE storage device. A host side issues a request that says whether the access is a read or a write. The request also carries a 5-bit register select and, for a write, the value to store. The controller then runs a fixed timed sequence on the device pins. First the chip selects and the address lines are presented for a setup period while both strobes stay high. Then the active-low read or write strobe is held low for a strobe period. A short hold period follows, in which the strobe is negated while the address is still held. Finally the chip selects are released and a one-cycle completion pulse is given, together with any read value.

The register select is split into the levels of the two active-low chip selects and the three active-high address bits. The select bits are passed to the pins as given, so any device register can be reached. The setup, strobe and hold lengths are parameters counted in system clocks. The setup and strobe defaults give about 10 µs at the default clock. The data bus is modelled as a separate output, output enable and input, so the pad ring can build the tri-state driver. A raw asynchronous reset is synchronised inside the block before use.

Top module: `atareg_ctrl`

## Requirements
- R1: While reset is applied and after it, until a request is accepted, both chip selects and both strobes are high, the address lines are 0, the data output enable is low, `rsp_done` is low and `busy` is low.
- R2: A request is accepted when `req_valid` is high at a clock edge while `busy` is low. From the next cycle, for exactly SETUP_CYC cycles, `dev_cs1_n` equals select bit 4, `dev_cs0_n` equals select bit 3 and `dev_addr` equals select bits 2..0, with both strobes high.
- R3: For a write (`req_write`=1), `dev_wr_n` is low for exactly STROBE_CYC consecutive cycles right after the setup period, and `dev_rd_n` stays high throughout.
- R4: For a read (`req_write`=0), `dev_rd_n` is low for exactly STROBE_CYC consecutive cycles right after the setup period, and `dev_wr_n` stays high throughout.
- R5: `dev_rd_n` and `dev_wr_n` are never low in the same cycle.
- R6: `dev_data_oe` is high only during the write strobe and the HOLD_CYC cycles after it. Whenever it is high, `dev_data_out` equals the write data given with the request.
- R7: For a read, `rsp_rdata` takes the value on `dev_data_in` at the last clock of the strobe period and holds it until a later read captures a new value. A write leaves `rsp_rdata` unchanged.
- R8: After the strobe there are exactly HOLD_CYC cycles with both strobes high and the select still on the pins. Then `rsp_done` is high for exactly one cycle, with both chip selects high and both strobes high.
- R9: A request presented while `busy` is high is ignored. Changes to `req_write`, `req_sel` or `req_wdata` after acceptance have no effect on the access in progress.
- R10: `busy` is high from the cycle after acceptance through the `rsp_done` cycle, which is SETUP_CYC+STROBE_CYC+HOLD_CYC+1 cycles in total. It is low in the cycle after that, when a new request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken when busy is low |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_sel | input | 5 | Bit 4: chip select 1 level; bit 3: chip select 0 level; bits 2..0: address |
| req_wdata | input | DATA_W | Write value |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last captured read value |
| dev_cs0_n | output | 1 | Device chip select 0, active low |
| dev_cs1_n | output | 1 | Device chip select 1, active low |
| dev_addr | output | 3 | Device register address, active high |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_data_out | output | DATA_W | Data driven toward the device |
| dev_data_oe | output | 1 | Output enable for the data bus driver |
| dev_data_in | input | DATA_W | Data bus as seen from the device |

## Verification
A phase counter that loads a wrong value or misses its terminal count shows at once as a setup, strobe or hold period of the wrong length. A sequencer stuck in one phase shows as a strobe or select that never releases, or as a missing completion pulse, within the span of one access. A command register that reloads during an access shows as select pins or write data that change in the middle of a strobe. A capture on the wrong clock shows at completion as a read value that differs from what the device drove on the final strobe cycle.

// File: rtl/atareg_pkg.sv
package atareg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } phase_e;

  localparam int SEL_W   = 5;
  localparam int CS1_POS = 4;
  localparam int CS0_POS = 3;
  localparam int ADDR_W  = 3;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/atareg_rst_sync.sv
module atareg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/atareg_timer.sv
module atareg_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/atareg_seq.sv
module atareg_seq
  import atareg_pkg::*;
#(
  parameter int SETUP_CYC  = 500,
  parameter int STROBE_CYC = 500,
  parameter int HOLD_CYC   = 2,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             tmr_expired,
  output phase_e           phase_q,
  output phase_e           phase_d,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] L_SETUP  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] L_STROBE = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] L_HOLD   = CNT_W'(HOLD_CYC - 1);

  always_comb begin
    phase_d  = phase_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          phase_d  = PH_SETUP;
          tmr_load = 1'b1;
          tmr_val  = L_SETUP;
        end
      end
      PH_SETUP: begin
        if (tmr_expired) begin
          phase_d  = PH_STROBE;
          tmr_load = 1'b1;
          tmr_val  = L_STROBE;
        end
      end
      PH_STROBE: begin
        if (tmr_expired) begin
          capture  = 1'b1;
          phase_d  = PH_HOLD;
          tmr_load = 1'b1;
          tmr_val  = L_HOLD;
        end
      end
      PH_HOLD: begin
        if (tmr_expired) phase_d = PH_DONE;
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/atareg_pins.sv
module atareg_pins
  import atareg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  phase_e            phase_d,
  input  logic              req_write,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dev_data_in,
  output logic              dev_cs0_n,
  output logic              dev_cs1_n,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dev_rd_n,
  output logic              dev_wr_n,
  output logic [DATA_W-1:0] dev_data_out,
  output logic              dev_data_oe,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);

  // latched command, loaded only on acceptance
  logic              cmd_wr_q,    cmd_wr_d;
  logic [SEL_W-1:0]  cmd_sel_q,   cmd_sel_d;
  logic [DATA_W-1:0] cmd_wdata_q, cmd_wdata_d;

  // pin registers, decoded from the next phase so the pins are glitch free
  logic              cs0_d, cs1_d, rd_d, wr_d, oe_d, done_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] dout_d;
  logic [DATA_W-1:0] rdata_d;
  logic              on_bus;

  always_comb begin
    cmd_wr_d    = accept ? req_write : cmd_wr_q;
    cmd_sel_d   = accept ? req_sel   : cmd_sel_q;
    cmd_wdata_d = accept ? req_wdata : cmd_wdata_q;

    on_bus = (phase_d == PH_SETUP) || (phase_d == PH_STROBE) || (phase_d == PH_HOLD);
    cs1_d  = on_bus ? cmd_sel_d[CS1_POS] : 1'b1;
    cs0_d  = on_bus ? cmd_sel_d[CS0_POS] : 1'b1;
    addr_d = on_bus ? cmd_sel_d[ADDR_W-1:0] : '0;
    wr_d   = !((phase_d == PH_STROBE) && cmd_wr_d);
    rd_d   = !((phase_d == PH_STROBE) && !cmd_wr_d);
    oe_d   = cmd_wr_d && ((phase_d == PH_STROBE) || (phase_d == PH_HOLD));
    dout_d = oe_d ? cmd_wdata_d : '0;
    done_d = (phase_d == PH_DONE);

    rdata_d = rsp_rdata;
    if (capture && !cmd_wr_q) rdata_d = dev_data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_wr_q     <= 1'b0;
      cmd_sel_q    <= '0;
      cmd_wdata_q  <= '0;
      dev_cs0_n    <= 1'b1;
      dev_cs1_n    <= 1'b1;
      dev_addr     <= '0;
      dev_rd_n     <= 1'b1;
      dev_wr_n     <= 1'b1;
      dev_data_oe  <= 1'b0;
      dev_data_out <= '0;
      rsp_done     <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      cmd_wr_q     <= cmd_wr_d;
      cmd_sel_q    <= cmd_sel_d;
      cmd_wdata_q  <= cmd_wdata_d;
      dev_cs0_n    <= cs0_d;
      dev_cs1_n    <= cs1_d;
      dev_addr     <= addr_d;
      dev_rd_n     <= rd_d;
      dev_wr_n     <= wr_d;
      dev_data_oe  <= oe_d;
      dev_data_out <= dout_d;
      rsp_done     <= done_d;
      rsp_rdata    <= rdata_d;
    end
  end

endmodule

// File: rtl/atareg_ctrl.sv
module atareg_ctrl
  import atareg_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CLK_MHZ    = 50,
  parameter int SETUP_CYC  = 10 * CLK_MHZ,
  parameter int STROBE_CYC = 10 * CLK_MHZ,
  parameter int HOLD_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [4:0]        req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dev_cs0_n,
  output logic              dev_cs1_n,
  output logic [2:0]        dev_addr,
  output logic              dev_rd_n,
  output logic              dev_wr_n,
  output logic [DATA_W-1:0] dev_data_out,
  output logic              dev_data_oe,
  input  logic [DATA_W-1:0] dev_data_in
);

  localparam int CNT_W = $clog2(max3(SETUP_CYC, STROBE_CYC, HOLD_CYC) + 1);

  logic             rst_n_s;
  phase_e           phase_q, phase_d;
  logic             accept, capture, tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  atareg_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  atareg_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  atareg_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .CNT_W      (CNT_W)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .req_valid   (req_valid),
    .tmr_expired (tmr_expired),
    .phase_q     (phase_q),
    .phase_d     (phase_d),
    .accept      (accept),
    .capture     (capture),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val)
  );

  atareg_pins #(.DATA_W(DATA_W)) i_pins (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .accept       (accept),
    .capture      (capture),
    .phase_d      (phase_d),
    .req_write    (req_write),
    .req_sel      (req_sel),
    .req_wdata    (req_wdata),
    .dev_data_in  (dev_data_in),
    .dev_cs0_n    (dev_cs0_n),
    .dev_cs1_n    (dev_cs1_n),
    .dev_addr     (dev_addr),
    .dev_rd_n     (dev_rd_n),
    .dev_wr_n     (dev_wr_n),
    .dev_data_out (dev_data_out),
    .dev_data_oe  (dev_data_oe),
    .rsp_done     (rsp_done),
    .rsp_rdata    (rsp_rdata)
  );

  assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/atareg_ctrl_chk.sv
module atareg_ctrl_chk #(
  parameter int DATA_W     = 16,
  parameter int STROBE_CYC = 500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_done,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              dev_cs0_n,
  input logic              dev_cs1_n,
  input logic [2:0]        dev_addr,
  input logic              dev_rd_n,
  input logic              dev_wr_n,
  input logic              dev_data_oe
);

  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    run_q <= '0;
    else if (!dev_rd_n || !dev_wr_n) run_q <= run_q + 32'd1;
    else                           run_q <= '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_rd_n && !dev_wr_n)); // R5

  AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 32'(STROBE_CYC)); // R3

  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dev_rd_n) || $rose(dev_wr_n)) |-> (run_q == 32'(STROBE_CYC))); // R4

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ((!dev_rd_n || !dev_wr_n) && $past(!dev_rd_n || !dev_wr_n)) |-> $stable(dev_addr)); // R2

  AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dev_data_oe |-> dev_rd_n); // R6

  AST_RDATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> (dev_rd_n && $past(!dev_rd_n))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R8

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (dev_cs0_n && dev_cs1_n && dev_rd_n && dev_wr_n && !dev_data_oe)); // R8

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy); // R10

  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !busy); // R10

endmodule

bind atareg_ctrl atareg_ctrl_chk #(
  .DATA_W     (DATA_W),
  .STROBE_CYC (STROBE_CYC)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .req_valid   (req_valid),
  .busy        (busy),
  .rsp_done    (rsp_done),
  .rsp_rdata   (rsp_rdata),
  .dev_cs0_n   (dev_cs0_n),
  .dev_cs1_n   (dev_cs1_n),
  .dev_addr    (dev_addr),
  .dev_rd_n    (dev_rd_n),
  .dev_wr_n    (dev_wr_n),
  .dev_data_oe (dev_data_oe)
);

// File: tb/test_atareg_ctrl.sv
module test_atareg_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;
  localparam int T_SETUP    = 3;
  localparam int T_STROBE   = 4;
  localparam int T_HOLD     = 2;
  localparam int T_BUSY     = T_SETUP + T_STROBE + T_HOLD + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [4:0]    req_sel;
  logic [DW-1:0] req_wdata;
  logic          busy;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          dev_cs0_n, dev_cs1_n;
  logic [2:0]    dev_addr;
  logic          dev_rd_n, dev_wr_n;
  logic [DW-1:0] dev_data_out;
  logic          dev_data_oe;
  logic [DW-1:0] dev_data_in;

  int n_cmp = 0;
  int n_mis = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atareg_ctrl #(
    .DATA_W     (DW),
    .SETUP_CYC  (T_SETUP),
    .STROBE_CYC (T_STROBE),
    .HOLD_CYC   (T_HOLD)
  ) i_atareg_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_sel      (req_sel),
    .req_wdata    (req_wdata),
    .busy         (busy),
    .rsp_done     (rsp_done),
    .rsp_rdata    (rsp_rdata),
    .dev_cs0_n    (dev_cs0_n),
    .dev_cs1_n    (dev_cs1_n),
    .dev_addr     (dev_addr),
    .dev_rd_n     (dev_rd_n),
    .dev_wr_n     (dev_wr_n),
    .dev_data_out (dev_data_out),
    .dev_data_oe  (dev_data_oe),
    .dev_data_in  (dev_data_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one access starting at a negedge; returns right after the negedge
  // at which busy has dropped again.
  task automatic run_access(input bit wr, input logic [4:0] sel,
                            input logic [DW-1:0] wd, input logic [DW-1:0] base,
                            input bit poke);
    int n_setup = 0, n_strb = 0, n_hold = 0, n_done = 0, n_busy = 0;
    int n_both = 0, n_badpin = 0, n_badoe = 0, n_badtype = 0, n_donepin = 0;
    bit seen_strb = 0, seen_done = 0;
    logic [DW-1:0] rd_before = rsp_rdata;
    logic [DW-1:0] exp_rd;
    req_valid = 1'b1;
    req_write = wr;
    req_sel   = sel;
    req_wdata = wd;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        if (poke) begin
          req_write = !wr;
          req_sel   = ~sel;
          req_wdata = ~wd;
        end else begin
          req_valid = 1'b0;
        end
      end
      if (seen_done && !busy) break;
      dev_data_in = 16'hDEAD;
      if (busy) n_busy++;
      if (!dev_rd_n && !dev_wr_n) n_both++;
      if (!dev_rd_n || !dev_wr_n) begin
        seen_strb = 1'b1;
        if ({dev_cs1_n, dev_cs0_n, dev_addr} != sel) n_badpin++;
        if (wr ? !(!dev_wr_n && dev_rd_n) : !(!dev_rd_n && dev_wr_n)) n_badtype++;
        if (dev_data_oe != wr || (wr && dev_data_out != wd)) n_badoe++;
        if (!wr) dev_data_in = base + DW'(n_strb);
        n_strb++;
      end else if (rsp_done) begin
        seen_done = 1'b1;
        n_done++;
        if (!(dev_cs0_n && dev_cs1_n && !dev_data_oe)) n_donepin++;
        req_valid = 1'b0;
      end else if (busy && !seen_strb) begin
        n_setup++;
        if ({dev_cs1_n, dev_cs0_n, dev_addr} != sel) n_badpin++;
        if (dev_data_oe) n_badoe++;
      end else if (busy) begin
        n_hold++;
        if ({dev_cs1_n, dev_cs0_n, dev_addr} != sel) n_badpin++;
        if (dev_data_oe != wr || (wr && dev_data_out != wd)) n_badoe++;
      end
    end
    exp_rd = wr ? rd_before : base + DW'(T_STROBE - 1);
    chk(n_setup == T_SETUP, "R2", "setup cycles", n_setup, T_SETUP);
    chk(n_badpin == 0, "R2/R9", "select pin mismatches", n_badpin, 0);
    if (wr) chk(n_strb == T_STROBE && n_badtype == 0, "R3", "write strobe cycles", n_strb, T_STROBE);
    else    chk(n_strb == T_STROBE && n_badtype == 0, "R4", "read strobe cycles", n_strb, T_STROBE);
    chk(n_both == 0, "R5", "both strobes low", n_both, 0);
    chk(n_badoe == 0, "R6", "data drive errors", n_badoe, 0);
    chk(rsp_rdata == exp_rd, "R7", "read data", rsp_rdata, exp_rd);
    chk(n_hold == T_HOLD, "R8", "hold cycles", n_hold, T_HOLD);
    chk(n_done == 1 && n_donepin == 0, "R8", "done pulses", n_done, 1);
    chk(n_busy == T_BUSY && !busy, "R10", "busy cycles", n_busy, T_BUSY);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_sel = '0;
    req_wdata = '0; dev_data_in = '0;
    repeat (3) @(negedge clk);
    chk(dev_cs0_n && dev_cs1_n && dev_rd_n && dev_wr_n && !dev_data_oe
        && !rsp_done && !busy && dev_addr == 0, "R1", "pins in reset",
        {dev_cs1_n, dev_cs0_n, dev_rd_n, dev_wr_n, dev_data_oe, rsp_done, busy}, 7'b1111000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dev_cs0_n && dev_cs1_n && dev_rd_n && dev_wr_n && !dev_data_oe && !busy,
        "R1", "pins after reset", {dev_cs1_n, dev_cs0_n, dev_rd_n, dev_wr_n, dev_data_oe, busy}, 6'b111100);
  endtask

  task automatic test_write();
    run_access(1'b1, 5'b10110, 16'hA55A, 16'h0000, 1'b0); // R3 R6
  endtask

  task automatic test_read();
    run_access(1'b0, 5'b01011, 16'h0000, 16'h1230, 1'b0); // R4 R7
  endtask

  task automatic test_write_keeps_rdata();
    run_access(1'b1, 5'b10001, 16'h0F0F, 16'h0000, 1'b0); // R7: 0x1233 stays
    chk(rsp_rdata == 16'h1233, "R7", "read data after write", rsp_rdata, 16'h1233);
  endtask

  task automatic test_busy_ignored();
    run_access(1'b0, 5'b01111, 16'h1111, 16'h4000, 1'b1); // R9
    repeat (3) begin
      @(negedge clk);
      chk(!busy && dev_cs0_n && dev_cs1_n, "R9", "no access from request while busy",
          {busy, dev_cs1_n, dev_cs0_n}, 3'b011);
    end
  endtask

  task automatic test_back_to_back();
    run_access(1'b0, 5'b01000, 16'h0000, 16'h7770, 1'b0); // R10
    run_access(1'b1, 5'b10101, 16'hFFFF, 16'h0000, 1'b0); // R10 immediate reuse
    chk(rsp_rdata == 16'h7773, "R7", "read data kept", rsp_rdata, 16'h7773);
  endtask

  initial begin
    test_reset();
    test_write();
    test_read();
    test_write_keeps_rdata();
    test_busy_ignored();
    test_back_to_back();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_mis++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

endmodule